// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block gives a processor three byte-wide parallel ports. Ports A and B carry data. Port C is a set of eight individually steerable lines. The processor reaches the block through a small synchronous register bus with a chip select, read and write strobes, a two-bit register select and a data byte. The control register takes two kinds of write. The first is a configuration word that sets the mode and direction of every port. The second is a single-bit command that sets or clears one port C line.

Ports A and B can each run as plain latched I/O or as strobed transfer ports. In strobed mode, three port C lines are taken over for that port: a strobe or acknowledge input, a buffer status output and an interrupt request output. Which lines are taken depends on the port and on its direction. Each port also keeps an interrupt enable flag. This flag is held inside the block and is reached only through the single-bit command on a fixed line position. Port C lines not claimed by a strobed port stay general-purpose, and their direction is set per half of the port.

All bus inputs and pins are sampled on the rising clock edge. Pin outputs and read data come from registers. Strobe and acknowledge are treated as signals that are already synchronous to the clock.

Top module: `hs_parallel_port`

## Requirements
- R1: A control write with bit 7 = 1 is a configuration word. The fields are: bits 6:5 set the port A mode (01 = strobed, anything else = plain); bit 4 sets the port A direction (1 = input); bit 3 sets the direction of PC7..PC4 (1 = input); bit 2 sets the port B mode (1 = strobed); bit 1 sets the port B direction (1 = input); bit 0 sets the direction of PC3..PC0 (1 = input). The output enables follow these fields from the next cycle. For example, word 0x86 gives port A plain output and port B strobed input.
- R2: Reset leaves all ports as plain inputs. Reset and every configuration word both clear the A, B and C output latches, clear the interrupt requests, input-full flags and enables, and leave each output-buffer-full line (active low) high.
- R3: The register select means 0 = port A, 1 = port B, 2 = port C, 3 = control. The read data is registered and is valid in the cycle after the read strobe. Reading control returns 0. Reading a port set as output returns its latch.
- R4: In plain mode, a write to an output port appears on its pins one cycle later. A read of an input port returns the pin value.
- R5: A control write with bit 7 = 0 sets or clears one port C bit. Bits 3:1 give the bit index and bit 0 gives the value. No other port C bit changes, and the configuration is unchanged.
- R6: When port A is a strobed input, PC4 is its strobe input (active low), PC5 is its input-full output and PC3 is its interrupt request. PC7 and PC6 stay general lines.
- R7: When port A is a strobed output, PC6 is its acknowledge input (active low), PC7 is its output-buffer-full output (active low) and PC3 is its interrupt request. PC5 and PC4 stay general lines.
- R8: When port B is strobed, in either direction, PC2 is its strobe or acknowledge input, PC1 is its input-full flag (input) or output-buffer-full flag (output, active low), and PC0 is its interrupt request.
- R9: The interrupt enable of a strobed port is changed only by the single-bit command at PC4 (port A input), PC6 (port A output) or PC2 (port B). That command leaves the port C latch bit and the pin unchanged. A port C read returns the enable at that bit position.
- R10: On a strobed input, each cycle with the strobe low latches the pins and sets input-full. When the strobe returns high while input-full and the enable are both set, the interrupt request is raised.
- R11: A read of a strobed input port clears its interrupt request in the following cycle and clears its input-full flag one cycle later. A strobe that is low in that later cycle keeps input-full set and latches the new byte.
- R12: On a strobed output, a port write drives output-buffer-full low and clears the interrupt request. An acknowledge low drives output-buffer-full high. An acknowledge rising edge with the enable set raises the interrupt request. A write in the same cycle as an acknowledge low leaves output-buffer-full low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select for the register bus |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| pa_in | input | DW | Port A pin input |
| pa_out | output | DW | Port A output latch |
| pa_oe | output | DW | Port A output enable per line |
| pb_in | input | DW | Port B pin input |
| pb_out | output | DW | Port B output latch |
| pb_oe | output | DW | Port B output enable per line |
| pc_in | input | 8 | Port C pin input, including strobe and acknowledge |
| pc_out | output | 8 | Port C output value, including handshake flags |
| pc_oe | output | 8 | Port C output enable per line |

## Verification
Two events can land in the same cycle. On a strobed input, the deferred input-full clear that follows a processor read can meet a new strobe. On a strobed output, a processor write can meet an acknowledge low. Each case is provoked by holding the strobe or acknowledge low across the cycle the bus access occupies. The result is judged on the port C flag line one cycle later: input-full must stay set with the new byte latched, and output-buffer-full must stay low. The interrupt line is then checked on the following strobe or acknowledge release.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

  localparam int unsigned PCW = 8;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } hpp_sel_e;

  typedef struct packed {
    logic a_hs;
    logic a_in;
    logic cu_in;
    logic b_hs;
    logic b_in;
    logic cl_in;
  } hpp_cfg_t;

  localparam hpp_cfg_t CFG_RESET = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                     b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // Port C line roles in strobed operation
  localparam logic [2:0] PC_INTR_B = 3'd0;
  localparam logic [2:0] PC_FLAG_B = 3'd1;
  localparam logic [2:0] PC_STB_B  = 3'd2;
  localparam logic [2:0] PC_INTR_A = 3'd3;
  localparam logic [2:0] PC_STB_A  = 3'd4;
  localparam logic [2:0] PC_IBF_A  = 3'd5;
  localparam logic [2:0] PC_ACK_A  = 3'd6;
  localparam logic [2:0] PC_OBF_A  = 3'd7;

  function automatic hpp_cfg_t decode_mode(input logic [7:0] w);
    hpp_cfg_t c;
    c.a_hs  = (w[6:5] == 2'b01);
    c.a_in  = w[4];
    c.cu_in = w[3];
    c.b_hs  = w[2];
    c.b_in  = w[1];
    c.cl_in = w[0];
    return c;
  endfunction

endpackage

// File: rtl/hpp_ctrl.sv
module hpp_ctrl
  import hpp_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           ctl_wr,
  input  logic           pc_wr,
  input  logic [7:0]     wdata,
  output hpp_cfg_t       cfg,
  output logic [PCW-1:0] pc_lat,
  output logic           inte_a,
  output logic           inte_b,
  output logic           mode_clr
);

  logic       bsr_wr;
  logic [2:0] bsr_idx;
  logic       bsr_val;
  logic       hit_a;
  logic       hit_b;

  assign mode_clr = ctl_wr & wdata[7];
  assign bsr_wr   = ctl_wr & ~wdata[7];
  assign bsr_idx  = wdata[3:1];
  assign bsr_val  = wdata[0];

  // The enable of a strobed port sits on its strobe/ack line position
  assign hit_a = cfg.a_hs && ((cfg.a_in  && bsr_idx == PC_STB_A) ||
                              (!cfg.a_in && bsr_idx == PC_ACK_A));
  assign hit_b = cfg.b_hs && (bsr_idx == PC_STB_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RESET;
      pc_lat <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else if (mode_clr) begin
      cfg    <= decode_mode(wdata);
      pc_lat <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else if (bsr_wr) begin
      if (hit_a)      inte_a <= bsr_val;
      else if (hit_b) inte_b <= bsr_val;
      else            pc_lat[bsr_idx] <= bsr_val;
    end else if (pc_wr) begin
      pc_lat <= wdata;
    end
  end

  // R5: a bit command never alters the configuration
  p_bsr_keeps_cfg_r5: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> $stable(cfg));

  // R5: a bit command outside the enable positions touches only one latch bit
  p_bsr_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (bsr_wr && !hit_a && !hit_b) |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1));

  // R2: a configuration word clears latch and enables
  p_mode_clears_r2: assert property (@(posedge clk) disable iff (rst)
    mode_clr |=> (pc_lat == '0 && !inte_a && !inte_b));

endmodule

// File: rtl/hpp_port_hs.sv
module hpp_port_hs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hs_en,
  input  logic          is_input,
  input  logic          inte,
  input  logic          stb_n,
  input  logic [DW-1:0] pin_in,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] out_lat,
  output logic          full,
  output logic          intr
);

  logic          s_prev;
  logic          rd_tail;
  logic [DW-1:0] in_q;
  logic          hs_in;
  logic          hs_out;
  logic          rise;
  logic          low;

  assign hs_in  = hs_en & is_input;
  assign hs_out = hs_en & ~is_input;
  assign rise   = ~s_prev & stb_n;
  assign low    = ~stb_n;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      s_prev  <= 1'b1;
      rd_tail <= 1'b0;
      in_q    <= '0;
      out_lat <= '0;
      full    <= 1'b0;
      intr    <= 1'b0;
    end else begin
      s_prev  <= stb_n;
      rd_tail <= hs_in & cpu_rd;
      if (cpu_wr) out_lat <= wdata;
      if (hs_in) begin
        if (low) begin
          in_q <= pin_in;
          full <= 1'b1;
        end else if (rd_tail) begin
          full <= 1'b0;
        end
        if (rise && full && inte) intr <= 1'b1;
        else if (cpu_rd)          intr <= 1'b0;
      end else if (hs_out) begin
        if (cpu_wr) begin
          full <= 1'b1;
          intr <= 1'b0;
        end else begin
          if (low)          full <= 1'b0;
          if (rise && inte) intr <= 1'b1;
        end
      end
    end
  end

  assign rd_val = is_input ? (hs_en ? in_q : pin_in) : out_lat;

  // R10: strobe low always leaves input-full set
  p_strobe_sets_full_r10: assert property (@(posedge clk) disable iff (rst)
    (hs_in && low && !clr) |=> full);

  // R11: a read without a competing strobe release drops the request
  p_read_drops_intr_r11: assert property (@(posedge clk) disable iff (rst)
    (hs_in && cpu_rd && !rise && !clr) |=> !intr);

  // R12: a port write marks the buffer full and withdraws the request
  p_write_fills_r12: assert property (@(posedge clk) disable iff (rst)
    (hs_out && cpu_wr && !clr) |=> (full && !intr));

  // R12: acknowledge low without a write empties the buffer
  p_ack_empties_r12: assert property (@(posedge clk) disable iff (rst)
    (hs_out && low && !cpu_wr && !clr) |=> !full);

endmodule

// File: rtl/hpp_pc_mux.sv
module hpp_pc_mux
  import hpp_pkg::*;
(
  input  hpp_cfg_t       cfg,
  input  logic [PCW-1:0] pc_lat,
  input  logic [PCW-1:0] pc_in,
  input  logic           a_full,
  input  logic           a_intr,
  input  logic           inte_a,
  input  logic           b_full,
  input  logic           b_intr,
  input  logic           inte_b,
  output logic [PCW-1:0] pc_out,
  output logic [PCW-1:0] pc_oe,
  output logic [PCW-1:0] pc_rd
);

  localparam int unsigned HALF = PCW / 2;

  always_comb begin
    for (int i = 0; i < PCW; i++) begin
      pc_oe[i] = (i >= HALF) ? ~cfg.cu_in : ~cfg.cl_in;
    end
    pc_out = pc_lat;
    pc_rd  = (pc_oe & pc_lat) | (~pc_oe & pc_in);

    if (cfg.b_hs) begin
      pc_oe[PC_INTR_B]  = 1'b1;
      pc_out[PC_INTR_B] = b_intr;
      pc_rd[PC_INTR_B]  = b_intr;
      pc_oe[PC_FLAG_B]  = 1'b1;
      pc_out[PC_FLAG_B] = cfg.b_in ? b_full : ~b_full;
      pc_rd[PC_FLAG_B]  = cfg.b_in ? b_full : ~b_full;
      pc_oe[PC_STB_B]   = 1'b0;
      pc_out[PC_STB_B]  = pc_lat[PC_STB_B];
      pc_rd[PC_STB_B]   = inte_b;
    end

    if (cfg.a_hs) begin
      pc_oe[PC_INTR_A]  = 1'b1;
      pc_out[PC_INTR_A] = a_intr;
      pc_rd[PC_INTR_A]  = a_intr;
      if (cfg.a_in) begin
        pc_oe[PC_STB_A]  = 1'b0;
        pc_out[PC_STB_A] = pc_lat[PC_STB_A];
        pc_rd[PC_STB_A]  = inte_a;
        pc_oe[PC_IBF_A]  = 1'b1;
        pc_out[PC_IBF_A] = a_full;
        pc_rd[PC_IBF_A]  = a_full;
      end else begin
        pc_oe[PC_ACK_A]  = 1'b0;
        pc_out[PC_ACK_A] = pc_lat[PC_ACK_A];
        pc_rd[PC_ACK_A]  = inte_a;
        pc_oe[PC_OBF_A]  = 1'b1;
        pc_out[PC_OBF_A] = ~a_full;
        pc_rd[PC_OBF_A]  = ~a_full;
      end
    end
  end

endmodule

// File: rtl/hs_parallel_port.sv
module hs_parallel_port
  import hpp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_cs,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [DW-1:0]  pa_in,
  output logic [DW-1:0]  pa_out,
  output logic [DW-1:0]  pa_oe,
  input  logic [DW-1:0]  pb_in,
  output logic [DW-1:0]  pb_out,
  output logic [DW-1:0]  pb_oe,
  input  logic [PCW-1:0] pc_in,
  output logic [PCW-1:0] pc_out,
  output logic [PCW-1:0] pc_oe
);

  localparam int NPORT = 2;

  hpp_sel_e       sel;
  logic           wr_hit;
  logic           rd_hit;
  hpp_cfg_t       cfg;
  logic [PCW-1:0] pc_lat;
  logic [PCW-1:0] pc_rd;
  logic           inte_a;
  logic           inte_b;
  logic           mode_clr;

  logic [DW-1:0]  p_pin  [NPORT];
  logic [DW-1:0]  p_rdv  [NPORT];
  logic [DW-1:0]  p_lat  [NPORT];
  logic           p_full [NPORT];
  logic           p_intr [NPORT];
  logic           p_hs   [NPORT];
  logic           p_dir  [NPORT];
  logic           p_inte [NPORT];
  logic           p_stb  [NPORT];
  logic           p_wr   [NPORT];
  logic           p_rd   [NPORT];

  assign sel    = hpp_sel_e'(bus_addr);
  assign wr_hit = bus_cs & bus_wr;
  assign rd_hit = bus_cs & bus_rd;

  hpp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (wr_hit && sel == SEL_CTL),
    .pc_wr    (wr_hit && sel == SEL_C),
    .wdata    (bus_wdata[7:0]),
    .cfg      (cfg),
    .pc_lat   (pc_lat),
    .inte_a   (inte_a),
    .inte_b   (inte_b),
    .mode_clr (mode_clr)
  );

  assign p_pin[0]  = pa_in;
  assign p_pin[1]  = pb_in;
  assign p_hs[0]   = cfg.a_hs;
  assign p_hs[1]   = cfg.b_hs;
  assign p_dir[0]  = cfg.a_in;
  assign p_dir[1]  = cfg.b_in;
  assign p_inte[0] = inte_a;
  assign p_inte[1] = inte_b;
  assign p_stb[0]  = cfg.a_in ? pc_in[PC_STB_A] : pc_in[PC_ACK_A];
  assign p_stb[1]  = pc_in[PC_STB_B];
  assign p_wr[0]   = wr_hit && sel == SEL_A;
  assign p_wr[1]   = wr_hit && sel == SEL_B;
  assign p_rd[0]   = rd_hit && sel == SEL_A;
  assign p_rd[1]   = rd_hit && sel == SEL_B;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    hpp_port_hs #(.DW(DW)) u_hs (
      .clk      (clk),
      .rst      (rst),
      .clr      (mode_clr),
      .hs_en    (p_hs[g]),
      .is_input (p_dir[g]),
      .inte     (p_inte[g]),
      .stb_n    (p_stb[g]),
      .pin_in   (p_pin[g]),
      .cpu_wr   (p_wr[g]),
      .cpu_rd   (p_rd[g]),
      .wdata    (bus_wdata),
      .rd_val   (p_rdv[g]),
      .out_lat  (p_lat[g]),
      .full     (p_full[g]),
      .intr     (p_intr[g])
    );
  end

  hpp_pc_mux u_pc_mux (
    .cfg    (cfg),
    .pc_lat (pc_lat),
    .pc_in  (pc_in),
    .a_full (p_full[0]),
    .a_intr (p_intr[0]),
    .inte_a (inte_a),
    .b_full (p_full[1]),
    .b_intr (p_intr[1]),
    .inte_b (inte_b),
    .pc_out (pc_out),
    .pc_oe  (pc_oe),
    .pc_rd  (pc_rd)
  );

  assign pa_out = p_lat[0];
  assign pb_out = p_lat[1];
  assign pa_oe  = {DW{~cfg.a_in}};
  assign pb_oe  = {DW{~cfg.b_in}};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      unique case (sel)
        SEL_A:   bus_rdata <= p_rdv[0];
        SEL_B:   bus_rdata <= p_rdv[1];
        SEL_C:   bus_rdata <= DW'(pc_rd);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R3: control register reads back as zero
  p_ctl_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel == SEL_CTL) |=> (bus_rdata == '0));

  // R3: read data holds between reads
  p_rdata_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(bus_rdata));

endmodule

// File: tb/hs_parallel_port_bench.sv
`timescale 1ns/1ps
module hs_parallel_port_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] pa_in = '0, pb_in = '0;
  logic [DW-1:0] pa_out, pa_oe, pb_out, pb_oe;
  logic [7:0]    pc_in = 8'hFF;
  logic [7:0]    pc_out, pc_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  hs_parallel_port #(.DW(DW)) u_hs_parallel_port (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual hung, expected finished run");
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_cs = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    check("R2", "pa_oe after reset", pa_oe, 8'h00);
    check("R2", "pb_oe after reset", pb_oe, 8'h00);
    check("R2", "pc_oe after reset", pc_oe, 8'h00);
    check("R2", "pa_out after reset", pa_out, 8'h00);
    check("R3", "rdata after reset", bus_rdata, 8'h00);
  endtask

  task automatic t_plain_io();
    logic [7:0] d;
    bus_write(2'd3, 8'h80);
    check("R1", "pa_oe all out", pa_oe, 8'hFF);
    check("R1", "pc_oe all out", pc_oe, 8'hFF);
    bus_write(2'd0, 8'h5A);
    check("R4", "pa_out write", pa_out, 8'h5A);
    bus_write(2'd1, 8'hA5);
    check("R4", "pb_out write", pb_out, 8'hA5);
    bus_read(2'd0, d);
    check("R3", "read output port A", d, 8'h5A);
    bus_write(2'd2, 8'h3C);
    check("R3", "pc_out write", pc_out, 8'h3C);
    bus_read(2'd2, d);
    check("R3", "read port C", d, 8'h3C);
    bus_read(2'd3, d);
    check("R3", "read control", d, 8'h00);
    bus_write(2'd3, 8'h04);
    check("R5", "clear bit 2", pc_out, 8'h38);
    bus_write(2'd3, 8'h0F);
    check("R5", "set bit 7", pc_out, 8'hB8);
    bus_write(2'd3, 8'h08);
    check("R5", "clear bit 4 plain mode", pc_out, 8'hA8);
    check("R5", "config unchanged", pc_oe, 8'hFF);
    bus_write(2'd3, 8'h80);
    check("R2", "mode clears pa_out", pa_out, 8'h00);
    check("R2", "mode clears pc latch", pc_out, 8'h00);
    bus_write(2'd3, 8'h9B);
    check("R1", "pa_oe all in", pa_oe, 8'h00);
    check("R1", "pc_oe all in", pc_oe, 8'h00);
    pa_in = 8'hE1;
    bus_read(2'd0, d);
    check("R4", "read input port A", d, 8'hE1);
    pc_in = 8'h6D;
    bus_read(2'd2, d);
    check("R4", "read input port C", d, 8'h6D);
    pc_in = 8'hFF;
  endtask

  task automatic t_a_strobed_in();
    logic [7:0] d;
    bus_write(2'd3, 8'hB8);
    check("R6", "pc_oe A strobed in", pc_oe, 8'h2F);
    check("R1", "pa_oe A input", pa_oe, 8'h00);
    // no enable: no request
    pa_in = 8'h11; pc_in[4] = 1'b0; tick();
    check("R10", "IBF after strobe", {7'd0, pc_out[5]}, 8'h01);
    pc_in[4] = 1'b1; tick();
    check("R10", "no INTR without enable", {7'd0, pc_out[3]}, 8'h00);
    bus_read(2'd0, d); tick();
    check("R11", "IBF cleared", {7'd0, pc_out[5]}, 8'h00);
    bus_write(2'd3, 8'h09);
    check("R9", "enable not on pin oe", {7'd0, pc_oe[4]}, 8'h00);
    check("R9", "enable not on pin out", {7'd0, pc_out[4]}, 8'h00);
    bus_read(2'd2, d);
    check("R9", "port C status read", d, 8'hD0);
    pa_in = 8'h3C; pc_in[4] = 1'b0; tick();
    check("R10", "IBF set", {7'd0, pc_out[5]}, 8'h01);
    check("R10", "INTR idle during strobe", {7'd0, pc_out[3]}, 8'h00);
    pc_in[4] = 1'b1; pa_in = 8'h99; tick();
    check("R10", "INTR on strobe release", {7'd0, pc_out[3]}, 8'h01);
    bus_read(2'd0, d);
    check("R10", "latched byte", d, 8'h3C);
    check("R11", "INTR cleared by read", {7'd0, pc_out[3]}, 8'h00);
    check("R11", "IBF held for read tail", {7'd0, pc_out[5]}, 8'h01);
    tick();
    check("R11", "IBF cleared after read", {7'd0, pc_out[5]}, 8'h00);
  endtask

  task automatic t_in_collision();
    logic [7:0] d;
    pa_in = 8'h42; pc_in[4] = 1'b0; tick();
    pc_in[4] = 1'b1; tick();
    bus_read(2'd0, d);
    check("R11", "first byte", d, 8'h42);
    pa_in = 8'h43; pc_in[4] = 1'b0; tick();
    check("R11", "strobe beats IBF clear", {7'd0, pc_out[5]}, 8'h01);
    pc_in[4] = 1'b1; tick();
    check("R11", "INTR for second byte", {7'd0, pc_out[3]}, 8'h01);
    bus_read(2'd0, d);
    check("R11", "second byte", d, 8'h43);
    tick();
  endtask

  task automatic t_a_strobed_out();
    logic [7:0] d;
    bus_write(2'd3, 8'hA4);
    check("R7", "pc_oe A out B out", pc_oe, 8'hBB);
    check("R1", "pa_oe A output", pa_oe, 8'hFF);
    check("R2", "idle flags", pc_out, 8'h82);
    bus_write(2'd0, 8'h77);
    check("R12", "pa_out", pa_out, 8'h77);
    check("R12", "OBF low on write", {7'd0, pc_out[7]}, 8'h00);
    pc_in[6] = 1'b0; tick();
    check("R12", "OBF high on ack", {7'd0, pc_out[7]}, 8'h01);
    pc_in[6] = 1'b1; tick();
    check("R12", "no INTR without enable", {7'd0, pc_out[3]}, 8'h00);
    bus_write(2'd3, 8'h0D);
    bus_read(2'd2, d);
    check("R9", "enable A at PC6", d, 8'hC2);
    bus_write(2'd0, 8'h78);
    pc_in[6] = 1'b0; tick();
    pc_in[6] = 1'b1; tick();
    check("R12", "INTR on ack release", {7'd0, pc_out[3]}, 8'h01);
    bus_write(2'd0, 8'h79);
    check("R12", "write clears INTR", {7'd0, pc_out[3]}, 8'h00);
    pc_in[6] = 1'b0; tick();
    check("R12", "ack empties", {7'd0, pc_out[7]}, 8'h01);
    bus_write(2'd0, 8'h7A);
    check("R12", "write beats ack low", {7'd0, pc_out[7]}, 8'h00);
    pc_in[6] = 1'b1; tick();
    bus_write(2'd1, 8'h55);
    check("R8", "pb_out", pb_out, 8'h55);
    check("R8", "OBF B low", {7'd0, pc_out[1]}, 8'h00);
    pc_in[2] = 1'b0; tick();
    check("R8", "OBF B high on ack", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1'b1; tick();
  endtask

  task automatic t_b_strobed_in();
    logic [7:0] d;
    bus_write(2'd3, 8'h86);
    check("R1", "0x86 pa_oe", pa_oe, 8'hFF);
    check("R1", "0x86 pb_oe", pb_oe, 8'h00);
    check("R8", "0x86 pc_oe", pc_oe, 8'hFB);
    bus_write(2'd3, 8'h05);
    check("R9", "PC2 stays input", {7'd0, pc_oe[2]}, 8'h00);
    pb_in = 8'hC7; pc_in[2] = 1'b0; tick();
    check("R8", "IBF B", {7'd0, pc_out[1]}, 8'h01);
    pc_in[2] = 1'b1; tick();
    check("R8", "INTR B", {7'd0, pc_out[0]}, 8'h01);
    bus_read(2'd1, d);
    check("R8", "port B byte", d, 8'hC7);
    check("R11", "INTR B cleared", {7'd0, pc_out[0]}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_plain_io();
    t_a_strobed_in();
    t_in_collision();
    t_a_strobed_out();
    t_b_strobed_in();
    summary();
    $finish;
  end

endmodule